// File: doc/BRIEF.md
# Power-Down Settle Sequencer

This block governs how the digital path of a stereo audio converter comes out of power-down. An active-low sleep input drives the path into reset at once, without waiting for a clock edge, and forces every output sample to two's-complement zero. When the sleep input is released, the block first passes the release through a synchronizer on the local clock. It then counts frames of the word-select clock. Real sample data is allowed through only after a fixed settling interval, and that interval depends on whether the interface is the clock master or a clock slave.

In slave mode the block does not begin anything at release. It keeps the internal logic in reset until the word-select clock shows the edge that marks a frame start for the selected serial format: a rising edge for left-justified data and a falling edge for I2S. Only after that edge does it count the settling frames. Mode and format are captured at release and stay fixed until the next power-down. Once the settling count is reached, the counter stops and the ready flag holds.

Top module: `pwrup_settle_seq`

## Requirements
- R1: Whenever `sleep_n` is low, `core_rst_n` is 0, `zero_force` is 1 and `ready` is 0. This takes effect without waiting for a clock edge.
- R2: After release, `zero_force` stays 1 and `ready` stays 0 until the settling count for the captured mode has been reached.
- R3: With `master_mode`=1 at release, word-select rising edges are counted from release onward (edges starting at least 8 clocks after release). `ready` rises, and `zero_force` falls, within 3 local clocks after the 4129th rising edge. Neither happens after the 4128th.
- R4: With `master_mode`=0 at release, `core_rst_n` stays 0 until the first start edge. The start edge is a rising word-select edge when `fmt_i2s`=0 and a falling edge when `fmt_i2s`=1. An edge of the other polarity does not start the sequence, and no word-select activity keeps the block in reset.
- R5: In slave mode, `ready` rises after the 4132nd rising word-select edge that follows the start edge. The start edge itself is not counted.
- R6: `master_mode` and `fmt_i2s` are captured on release. Later changes have no effect until the next power-down.
- R7: Once `ready` is 1, it stays 1 and `zero_force` stays 0 while word-select keeps running. The frame counter saturates at its terminal count.
- R8: Asserting `sleep_n` low in the middle of a count discards all progress. After the next release the full count is needed again.
- R9: The release passes through a two-stage synchronizer. In master mode, `core_rst_n` goes high on the third rising clock edge after `sleep_n` rises, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, much faster than word-select |
| sleep_n | input | 1 | Asynchronous power-down, low = sleep |
| ws_in | input | 1 | Word-select (frame) clock, asynchronous to `clk` |
| master_mode | input | 1 | 1 = clock master, 0 = clock slave |
| fmt_i2s | input | 1 | 1 = I2S framing, 0 = left-justified framing |
| core_rst_n | output | 1 | Active-low reset for internal logic and filter |
| zero_force | output | 1 | 1 = output samples forced to zero |
| ready | output | 1 | 1 = settling complete, real data flows |

## Verification
The hardest situation to reach from the ports is a power-down that lands in the middle of a long count. The leftover progress is invisible at the ports until a later run would finish early. To expose it, the stimulus aborts master-mode counting after a random number of frames and releases again. It then checks that `ready` is still low after one frame fewer than the full count. The slave start-edge rule is reached by presenting an edge of the wrong polarity first and confirming the reset holds. Mode and format inputs are flipped mid-count to show that they are ignored.

// File: rtl/settle_pkg.sv
package settle_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_COUNT = 2'd2,
    ST_RUN   = 2'd3
  } seq_state_t;

  // Number of frames to settle for a given interface role.
  function automatic int settle_target(input logic is_master, input int m_frames, input int s_frames);
    return is_master ? m_frames : s_frames;
  endfunction

  // Slave start edge polarity: I2S framing starts on a falling edge.
  function automatic logic start_on_fall(input logic i2s);
    return i2s;
  endfunction

endpackage

// File: rtl/rel_sync.sv
module rel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic async_n,
  output logic rel
);
  logic [STAGES-1:0] sy;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge async_n) begin
    if (!async_n) sy <= '0;
    else          sy <= {sy[STAGES-2:0], 1'b1};
  end

  assign rel = sy[STAGES-1];
endmodule

// File: rtl/ws_edge_det.sv
module ws_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ws_in,
  output logic rise_ev,
  output logic fall_ev
);
  logic [STAGES-1:0] sh;
  logic              prev;
  logic [STAGES:0]   prime;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh    <= '0;
      prev  <= 1'b0;
      prime <= '0;
    end else begin
      sh    <= {sh[STAGES-2:0], ws_in};
      prev  <= sh[STAGES-1];
      prime <= {prime[STAGES-1:0], 1'b1};
    end
  end

  // Edges seen while the pipeline is still filling are suppressed.
  assign rise_ev = prime[STAGES] &  sh[STAGES-1] & ~prev;
  assign fall_ev = prime[STAGES] & ~sh[STAGES-1] &  prev;
endmodule

// File: rtl/frame_counter.sv
module frame_counter #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic [CNT_W-1:0] target,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);
  logic at_top;

  assign at_top = (cnt == target);
  assign last   = inc && (cnt == target - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (inc && !at_top)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/settle_fsm.sv
module settle_fsm
  import settle_pkg::*;
#(
  parameter int CNT_W         = 13,
  parameter int MASTER_FRAMES = 4129,
  parameter int SLAVE_FRAMES  = 4132
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_mode,
  input  logic             fmt_i2s,
  input  logic             rise_ev,
  input  logic             fall_ev,
  input  logic             last,
  output seq_state_t       state,
  output logic [CNT_W-1:0] target_q,
  output logic             master_q,
  output logic             start_ev,
  output logic             cnt_inc
);
  logic fall_q;

  assign start_ev = fall_q ? fall_ev : rise_ev;
  assign cnt_inc  = (state == ST_COUNT) && rise_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      target_q <= '0;
      master_q <= 1'b0;
      fall_q   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          master_q <= master_mode;
          fall_q   <= start_on_fall(fmt_i2s);
          target_q <= CNT_W'(settle_target(master_mode, MASTER_FRAMES, SLAVE_FRAMES));
          state    <= master_mode ? ST_COUNT : ST_ARM;
        end
        ST_ARM:   if (start_ev) state <= ST_COUNT;
        ST_COUNT: if (last)     state <= ST_RUN;
        ST_RUN:   state <= ST_RUN;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwrup_settle_seq.sv
module pwrup_settle_seq
  import settle_pkg::*;
#(
  parameter int CNT_W         = 13,
  parameter int SYNC_STAGES   = 2,
  parameter int MASTER_FRAMES = 4129,
  parameter int SLAVE_FRAMES  = 4132
) (
  input  logic clk,
  input  logic sleep_n,
  input  logic ws_in,
  input  logic master_mode,
  input  logic fmt_i2s,
  output logic core_rst_n,
  output logic zero_force,
  output logic ready
);
  logic             rel;
  logic             rise_ev;
  logic             fall_ev;
  logic             start_ev;
  logic             cnt_inc;
  logic             last;
  logic             master_q;
  logic [CNT_W-1:0] target_q;
  logic [CNT_W-1:0] frame_cnt;
  seq_state_t       state;

  rel_sync #(.STAGES(SYNC_STAGES)) u_rel (
    .clk(clk), .async_n(sleep_n), .rel(rel)
  );

  ws_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rel), .ws_in(ws_in),
    .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  frame_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rel), .inc(cnt_inc), .target(target_q),
    .cnt(frame_cnt), .last(last)
  );

  settle_fsm #(
    .CNT_W(CNT_W), .MASTER_FRAMES(MASTER_FRAMES), .SLAVE_FRAMES(SLAVE_FRAMES)
  ) u_fsm (
    .clk(clk), .rst_n(rel), .master_mode(master_mode), .fmt_i2s(fmt_i2s),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .last(last),
    .state(state), .target_q(target_q), .master_q(master_q),
    .start_ev(start_ev), .cnt_inc(cnt_inc)
  );

  assign core_rst_n = (state == ST_COUNT) || (state == ST_RUN);
  assign zero_force = (state != ST_RUN);
  assign ready      = (state == ST_RUN);
endmodule

// File: rtl/settle_chk.sv
module settle_chk
  import settle_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input logic             clk,
  input logic             rel,
  input logic             master_q,
  input seq_state_t       state,
  input logic [CNT_W-1:0] frame_cnt,
  input logic [CNT_W-1:0] target_q,
  input logic             rise_ev,
  input logic             start_ev,
  input logic             core_rst_n,
  input logic             zero_force,
  input logic             ready
);
  a_r1_down_outputs: assert property (@(posedge clk)
    !rel |-> (!core_rst_n && zero_force && !ready));

  a_r2_zero_until_count: assert property (@(posedge clk) disable iff (!rel)
    (frame_cnt != target_q) |-> (zero_force && !ready));

  a_r3_ready_at_target: assert property (@(posedge clk) disable iff (!rel)
    $rose(ready) |-> (frame_cnt == target_q));

  a_r4_slave_start_edge: assert property (@(posedge clk) disable iff (!rel)
    ($rose(core_rst_n) && !master_q) |-> $past(start_ev));

  a_r5_count_on_rise: assert property (@(posedge clk) disable iff (!rel)
    !rise_ev |=> $stable(frame_cnt));

  a_r6_mode_held: assert property (@(posedge clk) disable iff (!rel)
    (state != ST_IDLE) |=> $stable(target_q));

  a_r7_ready_sticks: assert property (@(posedge clk) disable iff (!rel)
    ready |=> ready);

  a_r7_cnt_bounded: assert property (@(posedge clk) disable iff (!rel)
    frame_cnt <= target_q);
endmodule

bind pwrup_settle_seq settle_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rel(rel), .master_q(master_q), .state(state),
  .frame_cnt(frame_cnt), .target_q(target_q), .rise_ev(rise_ev),
  .start_ev(start_ev), .core_rst_n(core_rst_n), .zero_force(zero_force),
  .ready(ready)
);

// File: tb/tb_pwrup_settle_seq.sv
`timescale 1ns/1ps
module tb_pwrup_settle_seq;
  logic clk = 1'b0;
  logic sleep_n = 1'b0;
  logic ws_in = 1'b0;
  logic master_mode = 1'b1;
  logic fmt_i2s = 1'b0;
  logic core_rst_n, zero_force, ready;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pwrup_settle_seq dut (
    .clk(clk), .sleep_n(sleep_n), .ws_in(ws_in), .master_mode(master_mode),
    .fmt_i2s(fmt_i2s), .core_rst_n(core_rst_n), .zero_force(zero_force),
    .ready(ready)
  );

  // Bench's own view of the settling length.
  function automatic int exp_frames(input bit is_master);
    if (is_master) return 4129;
    return 4132;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One frame: rising edge, random high phase, falling edge, random low phase.
  task automatic frame();
    int hi = 2 + int'($urandom % 2);
    int lo = 2 + int'($urandom % 2);
    ws_in = 1'b1;
    repeat (hi) tick();
    ws_in = 1'b0;
    repeat (lo) tick();
  endtask

  task automatic run_frames(input int n);
    for (int i = 0; i < n; i++) frame();
  endtask

  task automatic go_down();
    tick();
    sleep_n = 1'b0;
    repeat (3) tick();
  endtask

  task automatic release_wait();
    sleep_n = 1'b1;
    repeat (10) tick();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (5) tick();
    // R1: reset state.
    chk(core_rst_n == 1'b0 && zero_force && !ready, "R1 reset state",
        {core_rst_n, zero_force, ready}, 3'b010);

    // ---- Master run with mid-count input changes ----
    master_mode = 1'b1; fmt_i2s = 1'b0; ws_in = 1'b0;
    sleep_n = 1'b1;
    tick(); tick();
    chk(core_rst_n == 1'b0, "R9 still held after two edges", core_rst_n, 0);
    tick();
    chk(core_rst_n == 1'b1, "R9 released on third edge", core_rst_n, 1);
    repeat (8) tick();
    run_frames(2000);
    chk(zero_force && !ready, "R2 zero forced mid count", {zero_force, ready}, 2'b10);
    master_mode = 1'b0; fmt_i2s = 1'b1;
    run_frames(exp_frames(1'b1) - 1 - 2000);
    chk(!ready && zero_force, "R3 master not ready one frame early (R6 inputs flipped)",
        ready, 0);
    run_frames(1);
    chk(ready && !zero_force, "R3 master ready at full count", ready, 1);
    chk(ready, "R6 captured master target used despite input change", ready, 1);
    begin
      int drops = 0;
      for (int i = 0; i < 40; i++) begin
        frame();
        if (!ready || zero_force) drops++;
      end
      chk(drops == 0, "R7 ready holds after saturation", drops, 0);
    end
    tick();
    sleep_n = 1'b0;
    #1;
    chk(!core_rst_n && zero_force && !ready, "R1 asynchronous power-down",
        {core_rst_n, zero_force, ready}, 3'b010);

    // ---- Abort mid-count (R8) ----
    master_mode = 1'b1; fmt_i2s = 1'b0;
    repeat (3) tick();
    release_wait();
    begin
      int part = 500 + int'($urandom % 1500);
      run_frames(part);
      chk(!ready, "R8 partial count not ready", ready, 0);
    end
    go_down();
    chk(!core_rst_n && zero_force && !ready, "R1 down during count",
        {core_rst_n, zero_force, ready}, 3'b010);
    release_wait();
    run_frames(exp_frames(1'b1) - 1);
    chk(!ready, "R8 progress discarded after abort", ready, 0);
    run_frames(1);
    chk(ready, "R8 full count after abort", ready, 1);

    // ---- Slave, left-justified: rising start edge (R4, R5) ----
    go_down();
    master_mode = 1'b0; fmt_i2s = 1'b0; ws_in = 1'b1;
    release_wait();
    chk(!core_rst_n, "R4 slave held without word-select activity", core_rst_n, 0);
    ws_in = 1'b0;
    repeat (4) tick();
    chk(!core_rst_n, "R4 falling edge ignored in left-justified", core_rst_n, 0);
    frame();
    chk(core_rst_n && zero_force, "R4 rising edge starts left-justified",
        {core_rst_n, zero_force}, 2'b11);
    run_frames(exp_frames(1'b0) - 1);
    chk(!ready, "R5 slave LJ not ready one frame early", ready, 0);
    run_frames(1);
    chk(ready && !zero_force, "R5 slave LJ ready at full count", ready, 1);

    // ---- Slave, I2S: falling start edge (R4, R5) ----
    go_down();
    master_mode = 1'b0; fmt_i2s = 1'b1; ws_in = 1'b0;
    release_wait();
    ws_in = 1'b1;
    repeat (4) tick();
    chk(!core_rst_n, "R4 rising edge ignored in I2S", core_rst_n, 0);
    ws_in = 1'b0;
    repeat (4) tick();
    chk(core_rst_n && zero_force, "R4 falling edge starts I2S",
        {core_rst_n, zero_force}, 2'b11);
    run_frames(exp_frames(1'b0) - 1);
    chk(!ready, "R5 slave I2S not ready one frame early", ready, 0);
    run_frames(1);
    chk(ready, "R5 slave I2S ready at full count", ready, 1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule